// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block keeps a small set of recent virtual-to-physical page translations and answers lookups in the same cycle. Any translation may sit in any slot. A lookup compares the virtual page number against every occupied slot at once. On a match it returns the physical address and checks whether the requested kind of access is allowed. On a mismatch it raises a miss so that software can trap, walk its page table and install the entry through the fill port.

Each slot holds status bits that the block maintains itself. A used bit records that the slot was hit. A dirty bit records a permitted write. Software clears the used bits when it samples page activity. When a fill arrives, the block chooses the slot to overwrite and reports that slot's current contents, so that software can write back a dirty page that is being evicted. A single control input drops every translation at once.

Top module: `xlat_cache`

## Requirements
- R1: While `lk_valid` is high, `lk_hit` is high exactly when an occupied slot holds a virtual page number equal to `lk_vaddr[VPN_W+OFF_W-1:OFF_W]`, and `lk_miss` is its complement. While `lk_valid` is low, both outputs are low.
- R2: On a hit, `lk_paddr` is the stored physical page number followed by the unchanged low `OFF_W` bits of `lk_vaddr`. Without a hit it is zero.
- R3: Rights codes are 00 read-only, 01 read/write, 10 read/execute and 11 read/write/execute. Access kinds are 00 read, 01 write, 10 execute, and 11, which is treated as a read. `lk_fault` is high on a hit whose kind the slot's rights do not allow, and is low otherwise.
- R4: A write hit that is allowed sets the slot's dirty bit at the next clock edge. A faulting write leaves the dirty bit unchanged. A fill loads the dirty bit from `fill_dirty`.
- R5: Any hit sets the slot's used bit at the next edge, including a hit that faults. `ref_clear` clears every used bit at the next edge. A hit in the same cycle still leaves its own slot's used bit set.
- R6: The fill slot is chosen in this order: the lowest-indexed unoccupied slot, otherwise the lowest-indexed slot whose used bit is clear, otherwise slot 0.
- R7: A `fill_we` pulse writes the virtual page number, physical page number, rights and dirty bit into the chosen slot. The slot is marked occupied and used, and it can be looked up from the next cycle.
- R8: `ev_valid`, `ev_dirty`, `ev_vpn` and `ev_ppn` show, combinationally, the current contents of the slot that a fill would overwrite. `ev_valid` is low when that slot is unoccupied, and `ev_dirty` is the stored dirty bit gated by occupancy.
- R9: `inv_all` marks every slot unoccupied at the next edge, and it takes priority over a fill in the same cycle.
- R10: After reset every slot is unoccupied, so lookups miss and `ev_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_kind | input | 2 | Access kind of the lookup |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| lk_hit | output | 1 | A matching translation was found |
| lk_miss | output | 1 | No matching translation; software refill needed |
| lk_fault | output | 1 | Hit, but the access kind is not permitted |
| lk_paddr | output | PPN_W+OFF_W | Translated physical address |
| fill_we | input | 1 | Install a translation into the chosen slot |
| fill_vpn | input | VPN_W | Virtual page number to install |
| fill_ppn | input | PPN_W | Physical page number to install |
| fill_rights | input | 2 | Rights code to install |
| fill_dirty | input | 1 | Initial dirty bit of the new translation |
| ev_valid | output | 1 | The slot that would be overwritten is occupied |
| ev_dirty | output | 1 | That slot's page is dirty |
| ev_vpn | output | VPN_W | That slot's virtual page number |
| ev_ppn | output | PPN_W | That slot's physical page number |
| ref_clear | input | 1 | Clear all used bits |
| inv_all | input | 1 | Drop every translation |

## Verification
All sixteen slots are filled with distinct page numbers, and the rights codes cycle through the four values. Every slot is then looked up with each of the three access kinds at varying offsets, which separates correct matching, address assembly and fault decisions slot by slot. The same pass also sets dirty bits only where a write is permitted. Addresses that no slot holds, and a lookup with the request low, separate a miss from an idle cycle.

Victim selection is tested on an empty table, on a full table with every used bit set, and after a used-bit clear followed by hits on a chosen prefix of slots. This shows the fall-back order and the eviction report, including dirty state left by faulting writes and by a fill. A same-cycle clear and hit, and a same-cycle invalidate and fill, test the two priority rules.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        RT_RO  = 2'b00,
        RT_RW  = 2'b01,
        RT_RX  = 2'b10,
        RT_RWX = 2'b11
    } rights_e;

    typedef enum logic [1:0] {
        AK_READ  = 2'b00,
        AK_WRITE = 2'b01,
        AK_EXEC  = 2'b10,
        AK_RSVD  = 2'b11
    } access_e;

    // bit 0 of the rights grants writes, bit 1 grants execution, reads always allowed
    function automatic logic access_ok(input logic [1:0] rights, input logic [1:0] kind);
        case (access_e'(kind))
            AK_WRITE: return rights[0];
            AK_EXEC:  return rights[1];
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            occ,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]              key,
    output logic                          found,
    output logic [IDX_W-1:0]              idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = occ[g] && (tags[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end

    assign found = |eq;
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] occ,
    input  logic [ENTRIES-1:0] used,
    output logic [IDX_W-1:0]   pick
);
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] cold_idx;
    logic             have_free;
    logic             have_cold;

    always_comb begin
        free_idx = '0;
        cold_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!occ[i])  free_idx = IDX_W'(i);
            if (!used[i]) cold_idx = IDX_W'(i);
        end
        have_free = ~&occ;
        have_cold = ~&used;
        if (have_free)      pick = free_idx;
        else if (have_cold) pick = cold_idx;
        else                pick = '0;
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 18,
    parameter int OFF_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VA_W   = VPN_W + OFF_W,
    localparam int PA_W   = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [1:0]       lk_kind,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             fill_we,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [1:0]       fill_rights,
    input  logic             fill_dirty,
    output logic             ev_valid,
    output logic             ev_dirty,
    output logic [VPN_W-1:0] ev_vpn,
    output logic [PPN_W-1:0] ev_ppn,
    input  logic             ref_clear,
    input  logic             inv_all
);
    import xlat_pkg::*;

    typedef struct packed {
        logic [ENTRIES-1:0]            occ;
        logic [ENTRIES-1:0]            used;
        logic [ENTRIES-1:0]            dirty;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [ENTRIES-1:0][1:0]       rights;
    } table_t;

    table_t st_d, st_q;

    logic             match_any;
    logic [IDX_W-1:0] match_idx;
    logic [IDX_W-1:0] vic_idx;
    logic             allowed;
    logic [VPN_W-1:0] key_vpn;
    logic [OFF_W-1:0] key_off;

    assign key_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign key_off = lk_vaddr[OFF_W-1:0];

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) match_i (
        .occ   (st_q.occ),
        .tags  (st_q.vpn),
        .key   (key_vpn),
        .found (match_any),
        .idx   (match_idx)
    );

    xlat_victim #(.ENTRIES(ENTRIES)) victim_i (
        .occ  (st_q.occ),
        .used (st_q.used),
        .pick (vic_idx)
    );

    // lookup side, purely combinational
    always_comb begin
        lk_hit   = lk_valid && match_any;
        lk_miss  = lk_valid && !match_any;
        allowed  = access_ok(st_q.rights[match_idx], lk_kind);
        lk_fault = lk_hit && !allowed;
        lk_paddr = lk_hit ? {st_q.ppn[match_idx], key_off} : '0;
    end

    assign ev_valid = st_q.occ[vic_idx];
    assign ev_dirty = st_q.occ[vic_idx] && st_q.dirty[vic_idx];
    assign ev_vpn   = st_q.vpn[vic_idx];
    assign ev_ppn   = st_q.ppn[vic_idx];

    // next-state: later statements take priority
    always_comb begin
        st_d = st_q;
        if (ref_clear) begin
            st_d.used = '0;
        end
        if (lk_hit) begin
            st_d.used[match_idx] = 1'b1;
            if (allowed && access_e'(lk_kind) == AK_WRITE) begin
                st_d.dirty[match_idx] = 1'b1;
            end
        end
        if (fill_we) begin
            st_d.occ[vic_idx]    = 1'b1;
            st_d.used[vic_idx]   = 1'b1;
            st_d.dirty[vic_idx]  = fill_dirty;
            st_d.vpn[vic_idx]    = fill_vpn;
            st_d.ppn[vic_idx]    = fill_ppn;
            st_d.rights[vic_idx] = fill_rights;
        end
        if (inv_all) begin
            st_d.occ = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 18,
    parameter int OFF_W = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_valid,
    input logic [VPN_W+OFF_W-1:0] lk_vaddr,
    input logic                   lk_hit,
    input logic                   lk_miss,
    input logic                   lk_fault,
    input logic [PPN_W+OFF_W-1:0] lk_paddr,
    input logic                   fill_we,
    input logic [VPN_W-1:0]       fill_vpn,
    input logic                   inv_all,
    input logic                   ev_valid
);
    a_r1_hit_miss_split: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit != lk_miss));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss));

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    a_r3_fault_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    a_r7_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && !inv_all) |=>
            ((lk_valid && lk_vaddr[VPN_W+OFF_W-1:OFF_W] == $past(fill_vpn)) |-> lk_hit));

    a_r9_flush_misses: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (lk_valid |-> lk_miss));

    a_r9_flush_frees: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !ev_valid);
endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_vaddr (lk_vaddr),
    .lk_hit   (lk_hit),
    .lk_miss  (lk_miss),
    .lk_fault (lk_fault),
    .lk_paddr (lk_paddr),
    .fill_we  (fill_we),
    .fill_vpn (fill_vpn),
    .inv_all  (inv_all),
    .ev_valid (ev_valid)
);

// File: tb/xlat_cache_tb_top.sv
`timescale 1ns/1ps
module xlat_cache_tb_top;
    localparam int ENTRIES = 16;
    localparam int VPN_W   = 20;
    localparam int PPN_W   = 18;
    localparam int OFF_W   = 12;
    localparam int VA_W    = VPN_W + OFF_W;
    localparam int PA_W    = PPN_W + OFF_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             lk_valid;
    logic [1:0]       lk_kind;
    logic [VA_W-1:0]  lk_vaddr;
    logic             lk_hit, lk_miss, lk_fault;
    logic [PA_W-1:0]  lk_paddr;
    logic             fill_we;
    logic [VPN_W-1:0] fill_vpn;
    logic [PPN_W-1:0] fill_ppn;
    logic [1:0]       fill_rights;
    logic             fill_dirty;
    logic             ev_valid, ev_dirty;
    logic [VPN_W-1:0] ev_vpn;
    logic [PPN_W-1:0] ev_ppn;
    logic             ref_clear, inv_all;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    xlat_cache #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_kind(lk_kind), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
        .fill_we(fill_we), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_rights(fill_rights), .fill_dirty(fill_dirty),
        .ev_valid(ev_valid), .ev_dirty(ev_dirty), .ev_vpn(ev_vpn), .ev_ppn(ev_ppn),
        .ref_clear(ref_clear), .inv_all(inv_all)
    );

    function automatic int vpn_of(int i); return i * 3 + 5; endfunction
    function automatic int ppn_of(int i); return i + 100; endfunction
    function automatic int rights_of(int i); return i % 4; endfunction
    function automatic bit kind_ok(int r, int k);
        if (k == 1) return (r == 1) || (r == 3);
        if (k == 2) return (r == 2) || (r == 3);
        return 1'b1;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_lookup(int vpn, int kind, int off);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_kind  = kind[1:0];
        lk_vaddr = {vpn[VPN_W-1:0], off[OFF_W-1:0]};
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        lk_valid  = 1'b0;
        fill_we   = 1'b0;
        ref_clear = 1'b0;
        inv_all   = 1'b0;
        #1;
    endtask

    task automatic do_fill(int vpn, int ppn, int r, bit d);
        @(negedge clk);
        lk_valid    = 1'b0;
        fill_we     = 1'b1;
        fill_vpn    = vpn[VPN_W-1:0];
        fill_ppn    = ppn[PPN_W-1:0];
        fill_rights = r[1:0];
        fill_dirty  = d;
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; lk_valid = 1'b0; lk_kind = '0; lk_vaddr = '0;
        fill_we = 1'b0; fill_vpn = '0; fill_ppn = '0; fill_rights = '0; fill_dirty = 1'b0;
        ref_clear = 1'b0; inv_all = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: empty after reset
        drive_lookup(vpn_of(0), 0, 0);
        chk("R10 reset miss", lk_miss, 1);
        chk("R10 reset no hit", lk_hit, 0);
        chk("R10 reset ev_valid", ev_valid, 0);

        // R6/R7: filling an empty table evicts nothing
        for (int i = 0; i < ENTRIES; i++) begin
            do_fill(vpn_of(i), ppn_of(i), rights_of(i), 1'b0);
            chk("R6 free slot used first", ev_valid, 0);
        end
        idle();
        chk("R6 full table victim occupied", ev_valid, 1);

        // R1/R2/R3/R4: every slot with every access kind
        for (int i = 0; i < ENTRIES; i++) begin
            for (int k = 0; k < 3; k++) begin
                int off;
                off = (i * 37 + k * 1111) % 4096;
                drive_lookup(vpn_of(i), k, off);
                chk("R1 hit", lk_hit, 1);
                chk("R1 no miss", lk_miss, 0);
                chk("R2 paddr", lk_paddr, (64'(ppn_of(i)) << OFF_W) | 64'(off));
                chk("R3 fault", lk_fault, !kind_ok(rights_of(i), k));
            end
        end

        // R1/R2: page numbers held by no slot
        for (int v = 0; v < 5; v++) begin
            drive_lookup(v, 0, 7);
            chk("R1 absent miss", lk_miss, 1);
            chk("R1 absent no hit", lk_hit, 0);
            chk("R2 paddr zero on miss", lk_paddr, 0);
        end
        drive_lookup(vpn_of(ENTRIES), 1, 3);
        chk("R1 absent beyond range", lk_miss, 1);
        chk("R3 no fault on miss", lk_fault, 0);
        idle();
        chk("R1 idle hit low", lk_hit, 0);
        chk("R1 idle miss low", lk_miss, 0);

        // R6/R8/R4: all used -> slot 0; its faulted write left it clean
        chk("R6 fallback slot0 vpn", ev_vpn, vpn_of(0));
        chk("R8 fallback slot0 ppn", ev_ppn, ppn_of(0));
        chk("R4 faulted write not dirty", ev_dirty, 0);

        // R5: clear with same-cycle faulting hit on slot 0, then hit slots 1 and 2
        drive_lookup(vpn_of(0), 1, 0);
        ref_clear = 1'b1;
        chk("R3 write to read-only faults", lk_fault, 1);
        drive_lookup(vpn_of(1), 0, 0);
        ref_clear = 1'b0;
        drive_lookup(vpn_of(2), 0, 0);
        idle();
        chk("R5 clear and hit priority victim", ev_vpn, vpn_of(3));
        chk("R8 victim ppn", ev_ppn, ppn_of(3));
        chk("R4 permitted write dirty", ev_dirty, 1);
        chk("R8 victim occupied", ev_valid, 1);

        // R7: fill over slot 3 with a dirty translation
        do_fill(200, 300, 1, 1'b1);
        idle();
        chk("R6 next cold slot", ev_vpn, vpn_of(4));
        chk("R4 read-only slot clean", ev_dirty, 0);
        drive_lookup(vpn_of(3), 0, 0);
        chk("R7 old translation gone", lk_miss, 1);
        drive_lookup(200, 1, 12'h5A5);
        chk("R7 new translation hit", lk_hit, 1);
        chk("R7 new paddr", lk_paddr, (64'd300 << OFF_W) | 64'h5A5);
        chk("R7 new rights", lk_fault, 0);

        // R5/R4: clear alone, touch 0..2, victim is the new slot with its dirty bit
        idle();
        @(negedge clk); ref_clear = 1'b1;
        drive_lookup(vpn_of(0), 0, 0);
        ref_clear = 1'b0;
        drive_lookup(vpn_of(1), 2, 0);
        drive_lookup(vpn_of(2), 0, 0);
        idle();
        chk("R5 clear then hits victim", ev_vpn, 200);
        chk("R4 fill dirty kept", ev_dirty, 1);

        // R9: flush together with a fill
        do_fill(77, 1, 3, 1'b0);
        inv_all = 1'b1;
        idle();
        chk("R9 flush frees victim", ev_valid, 0);
        chk("R9 flush no dirty report", ev_dirty, 0);
        drive_lookup(77, 0, 0);
        chk("R9 flush beats fill", lk_miss, 1);
        for (int i = 0; i < ENTRIES; i++) begin
            drive_lookup(vpn_of(i), 0, 0);
            chk("R9 all dropped", lk_hit, 0);
        end

        // R7/R3: refill after flush, execute on read/execute slot
        do_fill(9, 1, 2, 1'b0);
        drive_lookup(9, 2, 12'hFFF);
        fill_we = 1'b0;
        chk("R7 refill after flush", lk_hit, 1);
        chk("R3 exec permitted", lk_fault, 0);
        chk("R2 top offset", lk_paddr, (64'd1 << OFF_W) | 64'hFFF);
        drive_lookup(9, 1, 0);
        chk("R3 write on exec slot faults", lk_fault, 1);
        idle();

        finish_run();
    end
endmodule